// File: doc/BRIEF.md
# SPI Master Register Block

This block is the host-facing register file of an SPI master. It presents a single-cycle bus slave with a 5-bit byte address and 32-bit data. The host uses it to load four transmit words, set up the transfer format, pick the serial clock divider and choose which slave-select lines to drive. The shift datapath and the serial clock generator sit outside this block. They receive the transmit words, the format fields and a one-cycle start pulse, and they return the received words and a done pulse.

The first four word addresses serve two purposes. A write there stores a transmit word, and a read there returns a received word. A go/busy bit in the control word starts a transfer and clears itself when the datapath reports done. While a transfer runs, the block protects the transmit words and the control word. An interrupt output can flag the end of each transfer, and any completed bus access clears it. Eight active-low select pads follow the select register in one of two ways: directly, or only for the duration of a transfer.

Top module: `spi_regs`

## Requirements
- R1: After a synchronous active-high reset, the control word reads 0, the divider reads 0x0000FFFF and the select register reads 0. `ss_n` is all ones, and `irq`, `bus_ack` and `bus_err` are 0.
- R2: An access with `bus_cyc`, `bus_stb` and all four byte selects high is acknowledged one clock later by a one-cycle `bus_ack`. Read data is valid with that `bus_ack`, and `bus_err` stays low.
- R3: An access with any byte select low gets a one-cycle `bus_err` and no `bus_ack`, and it changes no register.
- R4: At byte addresses 0x00, 0x04, 0x08 and 0x0C, a read returns received word 0 to 3 from `rx_data`, and a write stores transmit word 0 to 3. Word i appears on bits [32i+31:32i] of `tx_data`.
- R5: The control word is at 0x10 with this layout: bits 6:0 are the character length, bit 8 is go, bit 9 is receive-on-falling, bit 10 is transmit-on-falling, bit 11 is LSB-first, bit 12 is interrupt enable and bit 13 is automatic select. All other bits read 0. The divider is at 0x14 and holds bits 15:0. The select register is at 0x18 and holds bits 7:0. Unmapped addresses read 0.
- R6: Writing the control word with bit 8 set while idle sets go, which is `xfer_go`, and drives `xfer_start` high for exactly one cycle. Writing it with bit 8 clear starts nothing.
- R7: A `xfer_done` pulse while go is set clears go in the next cycle.
- R8: While go is set, writes to the transmit words and to the control word are acknowledged but leave those registers unchanged.
- R9: When `xfer_done` ends a transfer and interrupt enable is 1, `irq` goes high on the next clock. When interrupt enable is 0, `irq` stays low.
- R10: Any acknowledged read or write clears `irq` on the same edge that raises `bus_ack`.
- R11: With automatic select clear, `ss_n` equals the bitwise inverse of the select register, one clock after the register changes.
- R12: With automatic select set, `ss_n` is the inverse of the select register while go is set, and all ones otherwise. `ss_n` follows go with one clock of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_cyc | input | 1 | Bus cycle valid |
| bus_stb | input | 1 | Slave strobe |
| bus_we | input | 1 | Write enable |
| bus_adr | input | 5 | Byte address |
| bus_sel | input | 4 | Byte selects; all must be high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_ack | output | 1 | Registered acknowledge |
| bus_err | output | 1 | Registered error response |
| irq | output | 1 | Registered end-of-transfer interrupt |
| xfer_start | output | 1 | One-cycle transfer start pulse |
| xfer_go | output | 1 | Go/busy state |
| xfer_done | input | 1 | Transfer finished pulse from the datapath |
| char_len | output | 7 | Character length field |
| lsb_first | output | 1 | LSB-first selection |
| tx_neg | output | 1 | Transmit on falling serial clock edge |
| rx_neg | output | 1 | Sample on falling serial clock edge |
| clk_div | output | 16 | Serial clock divider |
| tx_data | output | 128 | Four transmit words |
| rx_data | input | 128 | Four received words |
| ss_n | output | 8 | Active-low slave-select pads |

## Verification
The bench writes the transmit and control words while a transfer is running. A design without busy protection would show the new transmit word on `tx_data` or read back a cleared go bit. The bench reads the control word right after a done pulse, which confirms that go self-clears and that this read also clears `irq`. A block that only cleared the interrupt on writes, or that raised it with interrupt enable at 0, would leave `irq` in the wrong state. The bench also sends a partial byte-select write, where a faulty block would acknowledge it or corrupt the divider. Finally, it tracks `ss_n` across mode changes, so pads that stay active in automatic mode while idle are caught.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;
  localparam int unsigned LEN_W   = 7;
  localparam int unsigned B_GO    = 8;
  localparam int unsigned B_RXNEG = 9;
  localparam int unsigned B_TXNEG = 10;
  localparam int unsigned B_LSB   = 11;
  localparam int unsigned B_IE    = 12;
  localparam int unsigned B_AUTO  = 13;

  typedef struct packed {
    logic             auto_ss;
    logic             ie;
    logic             lsb;
    logic             txneg;
    logic             rxneg;
    logic [LEN_W-1:0] len;
  } ctrl_t;
endpackage

// File: rtl/spi_regs_bus.sv
module spi_regs_bus #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned SEL_W = DATA_W / 8,
  localparam int unsigned IDX_W = ADDR_W - 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc,
  input  logic             stb,
  input  logic             we,
  input  logic [ADDR_W-1:0] adr,
  input  logic [SEL_W-1:0] sel,
  output logic             ack,
  output logic             err,
  output logic             acc_ok,
  output logic             wr_ok,
  output logic [IDX_W-1:0] idx
);
  logic req;
  logic full;

  assign req    = cyc & stb & ~ack & ~err;
  assign full   = &sel;
  assign acc_ok = req & full;
  assign wr_ok  = acc_ok & we;
  assign idx    = adr[ADDR_W-1:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      ack <= 1'b0;
      err <= 1'b0;
    end else begin
      ack <= req & full;
      err <= req & ~full;
    end
  end
endmodule

// File: rtl/spi_regs_ctrl.sv
module spi_regs_ctrl
  import spi_regs_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic              acc_ok,
  input  logic [DATA_W-1:0] wdata,
  input  logic              done,
  output ctrl_t             ctrl,
  output logic              go,
  output logic              start,
  output logic              irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl  <= '0;
      go    <= 1'b0;
      start <= 1'b0;
    end else begin
      start <= 1'b0;
      if (wr_ctrl && !go) begin
        ctrl.len     <= wdata[LEN_W-1:0];
        ctrl.rxneg   <= wdata[B_RXNEG];
        ctrl.txneg   <= wdata[B_TXNEG];
        ctrl.lsb     <= wdata[B_LSB];
        ctrl.ie      <= wdata[B_IE];
        ctrl.auto_ss <= wdata[B_AUTO];
        if (wdata[B_GO]) begin
          go    <= 1'b1;
          start <= 1'b1;
        end
      end else if (go && done) begin
        go <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
    end else if (go && done && ctrl.ie) begin
      irq <= 1'b1;
    end else if (acc_ok) begin
      irq <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_regs_ss.sv
module spi_regs_ss #(
  parameter int unsigned SS_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_ss,
  input  logic [SS_W-1:0] wdata,
  input  logic            auto_ss,
  input  logic            go,
  output logic [SS_W-1:0] ss_q,
  output logic [SS_W-1:0] ss_n
);
  logic [SS_W-1:0] active;

  assign active = auto_ss ? (go ? ss_q : '0) : ss_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ss_q <= '0;
      ss_n <= '1;
    end else begin
      if (wr_ss) ss_q <= wdata;
      ss_n <= ~active;
    end
  end
endmodule

// File: rtl/spi_regs.sv
module spi_regs
  import spi_regs_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned NUM_WORDS = 4,
  parameter int unsigned SS_W      = 8,
  parameter int unsigned DIV_W     = 16,
  parameter logic [DIV_W-1:0] DIV_RESET = '1,
  localparam int unsigned SEL_W    = DATA_W / 8,
  localparam int unsigned IDX_W    = ADDR_W - 2,
  localparam int unsigned BUF_W    = NUM_WORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_cyc,
  input  logic              bus_stb,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_adr,
  input  logic [SEL_W-1:0]  bus_sel,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ack,
  output logic              bus_err,
  output logic              irq,
  output logic              xfer_start,
  output logic              xfer_go,
  input  logic              xfer_done,
  output logic [LEN_W-1:0]  char_len,
  output logic              lsb_first,
  output logic              tx_neg,
  output logic              rx_neg,
  output logic [DIV_W-1:0]  clk_div,
  output logic [BUF_W-1:0]  tx_data,
  input  logic [BUF_W-1:0]  rx_data,
  output logic [SS_W-1:0]   ss_n
);
  localparam logic [IDX_W-1:0] IDX_CTRL = IDX_W'(NUM_WORDS);
  localparam logic [IDX_W-1:0] IDX_DIV  = IDX_W'(NUM_WORDS + 1);
  localparam logic [IDX_W-1:0] IDX_SS   = IDX_W'(NUM_WORDS + 2);

  logic             acc_ok;
  logic             wr_ok;
  logic [IDX_W-1:0] idx;
  ctrl_t            ctrl;
  logic [SS_W-1:0]  ss_q;
  logic [DIV_W-1:0] div_q;
  logic [DATA_W-1:0] rd_mux;

  spi_regs_bus #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bus (
    .clk(clk), .rst(rst), .cyc(bus_cyc), .stb(bus_stb), .we(bus_we),
    .adr(bus_adr), .sel(bus_sel), .ack(bus_ack), .err(bus_err),
    .acc_ok(acc_ok), .wr_ok(wr_ok), .idx(idx)
  );

  spi_regs_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ok && idx == IDX_CTRL),
    .acc_ok(acc_ok), .wdata(bus_wdata), .done(xfer_done),
    .ctrl(ctrl), .go(xfer_go), .start(xfer_start), .irq(irq)
  );

  spi_regs_ss #(.SS_W(SS_W)) u_ss (
    .clk(clk), .rst(rst), .wr_ss(wr_ok && idx == IDX_SS),
    .wdata(bus_wdata[SS_W-1:0]), .auto_ss(ctrl.auto_ss), .go(xfer_go),
    .ss_q(ss_q), .ss_n(ss_n)
  );

  // Transmit words: one register per word, frozen while a transfer runs
  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_tx
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (rst) word_q <= '0;
      else if (wr_ok && !xfer_go && idx == IDX_W'(i)) word_q <= bus_wdata;
    end
    assign tx_data[i*DATA_W +: DATA_W] = word_q;
  end

  always_ff @(posedge clk) begin
    if (rst) div_q <= DIV_RESET;
    else if (wr_ok && idx == IDX_DIV) div_q <= bus_wdata[DIV_W-1:0];
  end

  always_comb begin
    rd_mux = '0;
    if (idx < IDX_CTRL) begin
      for (int i = 0; i < NUM_WORDS; i++) begin
        if (idx == IDX_W'(i)) rd_mux = rx_data[i*DATA_W +: DATA_W];
      end
    end else if (idx == IDX_CTRL) begin
      rd_mux[LEN_W-1:0] = ctrl.len;
      rd_mux[B_GO]      = xfer_go;
      rd_mux[B_RXNEG]   = ctrl.rxneg;
      rd_mux[B_TXNEG]   = ctrl.txneg;
      rd_mux[B_LSB]     = ctrl.lsb;
      rd_mux[B_IE]      = ctrl.ie;
      rd_mux[B_AUTO]    = ctrl.auto_ss;
    end else if (idx == IDX_DIV) begin
      rd_mux[DIV_W-1:0] = div_q;
    end else if (idx == IDX_SS) begin
      rd_mux[SS_W-1:0] = ss_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (acc_ok) bus_rdata <= rd_mux;
  end

  assign char_len  = ctrl.len;
  assign lsb_first = ctrl.lsb;
  assign tx_neg    = ctrl.txneg;
  assign rx_neg    = ctrl.rxneg;
  assign clk_div   = div_q;
endmodule

// File: rtl/spi_regs_chk.sv
module spi_regs_chk #(
  parameter int unsigned DIV_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_ack,
  input logic             bus_err,
  input logic             irq,
  input logic             xfer_start,
  input logic             xfer_go,
  input logic             xfer_done,
  input logic [DIV_W-1:0] clk_div
);
  a_r2_ack_err_excl: assert property (@(posedge clk) disable iff (rst)
    !(bus_ack && bus_err));
  a_r2_single_ack: assert property (@(posedge clk) disable iff (rst)
    bus_ack |=> !bus_ack);
  a_r3_err_keeps_div: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> $stable(clk_div));
  a_r6_start_sets_go: assert property (@(posedge clk) disable iff (rst)
    xfer_start |-> xfer_go);
  a_r6_start_pulse: assert property (@(posedge clk) disable iff (rst)
    xfer_start |=> !xfer_start);
  a_r7_done_clears_go: assert property (@(posedge clk) disable iff (rst)
    (xfer_go && xfer_done) |=> !xfer_go);
  a_r9_irq_after_done: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(xfer_done));
endmodule

bind spi_regs spi_regs_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .bus_ack(bus_ack), .bus_err(bus_err), .irq(irq),
  .xfer_start(xfer_start), .xfer_go(xfer_go), .xfer_done(xfer_done),
  .clk_div(clk_div)
);

// File: tb/spi_regs_bench.sv
module spi_regs_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_cyc = 1'b0, bus_stb = 1'b0, bus_we = 1'b0;
  logic [4:0]   bus_adr = '0;
  logic [3:0]   bus_sel = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         bus_ack, bus_err, irq, xfer_start, xfer_go;
  logic         xfer_done = 1'b0;
  logic [6:0]   char_len;
  logic         lsb_first, tx_neg, rx_neg;
  logic [15:0]  clk_div;
  logic [127:0] tx_data;
  logic [127:0] rx_data = {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111};
  logic [7:0]   ss_n;

  int n_tests = 0;
  int n_fail  = 0;
  logic        rd_flag = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        g_ack, g_err;

  always #4 clk = ~clk;

  spi_regs u_spi_regs (
    .clk(clk), .rst(rst), .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we),
    .bus_adr(bus_adr), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err), .irq(irq),
    .xfer_start(xfer_start), .xfer_go(xfer_go), .xfer_done(xfer_done),
    .char_len(char_len), .lsb_first(lsb_first), .tx_neg(tx_neg), .rx_neg(rx_neg),
    .clk_div(clk_div), .tx_data(tx_data), .rx_data(rx_data), .ss_n(ss_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: compares each read acknowledge against the scoreboard
  always @(negedge clk) begin
    if (bus_ack && rd_flag) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected read ack", bus_rdata, 32'h0);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(bus_rdata == e, t, bus_rdata, e);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_xfer(input logic we, input logic [4:0] a, input logic [31:0] d,
                          input logic [3:0] s);
    @(negedge clk);
    rd_flag = !we;
    bus_cyc = 1'b1; bus_stb = 1'b1; bus_we = we;
    bus_adr = a; bus_wdata = d; bus_sel = s;
    @(posedge clk);
    @(negedge clk);
    g_ack = bus_ack; g_err = bus_err;
    bus_cyc = 1'b0; bus_stb = 1'b0; bus_we = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input string req);
    bus_xfer(1'b1, a, d, 4'hF);
    chk(g_ack && !g_err, req, {30'h0, g_ack, g_err}, 32'h2);
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string req);
    exp_q.push_back(e);
    tag_q.push_back(req);
    bus_xfer(1'b0, a, 32'h0, 4'hF);
    chk(g_ack && !g_err, req, {30'h0, g_ack, g_err}, 32'h2);
  endtask

  task automatic done_pulse();
    @(negedge clk);
    xfer_done = 1'b1;
    @(posedge clk);
    @(negedge clk);
    xfer_done = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(ss_n == 8'hFF, "R1 ss_n", {24'h0, ss_n}, 32'hFF);
    chk({irq, bus_ack, bus_err} == 3'b000, "R1 irq/ack/err", {29'h0, irq, bus_ack, bus_err}, 32'h0);
    rd(5'h10, 32'h0, "R1 ctrl reset");
    rd(5'h14, 32'h0000_FFFF, "R1 divider reset");
    rd(5'h18, 32'h0, "R1 select reset");

    // R4 transmit words and receive words
    for (int i = 0; i < 4; i++) wr(5'(i * 4), 32'hA0A0_A0A0 + 32'(i), "R4 tx write ack");
    for (int i = 0; i < 4; i++)
      chk(tx_data[i*32 +: 32] == 32'hA0A0_A0A0 + 32'(i), "R4 tx word",
          tx_data[i*32 +: 32], 32'hA0A0_A0A0 + 32'(i));
    for (int i = 0; i < 4; i++) rd(5'(i * 4), 32'h1111_1111 * 32'(i + 1), "R4 rx word read");

    // R11 manual select
    wr(5'h18, 32'h0000_A5A5, "R2 select write");
    tick();
    chk(ss_n == 8'h5A, "R11 manual ss_n", {24'h0, ss_n}, 32'h5A);
    rd(5'h18, 32'h0000_00A5, "R5 select field");

    // R5 control layout and divider
    wr(5'h10, 32'hFFFF_FEFF, "R5 ctrl write");
    chk(!xfer_start, "R6 no start without bit 8", {31'h0, xfer_start}, 32'h0);
    rd(5'h10, 32'h0000_3E7F, "R5 ctrl layout");
    chk(char_len == 7'h7F && lsb_first && tx_neg && rx_neg, "R5 format outputs",
        {21'h0, lsb_first, tx_neg, rx_neg, 1'b0, char_len}, 32'h0000_077F);
    wr(5'h14, 32'h1234_5678, "R5 divider write");
    rd(5'h14, 32'h0000_5678, "R5 divider field");
    rd(5'h1C, 32'h0, "R5 unmapped reads zero");

    // R12 automatic select idle
    wr(5'h10, 32'h0000_2000, "R12 auto mode write");
    tick();
    chk(ss_n == 8'hFF, "R12 auto idle ss_n", {24'h0, ss_n}, 32'hFF);

    // R6 start transfer with interrupt enable
    wr(5'h10, 32'h0000_3108, "R6 go write");
    chk(xfer_start && xfer_go, "R6 start pulse high", {30'h0, xfer_start, xfer_go}, 32'h3);
    tick();
    chk(!xfer_start, "R6 start pulse one cycle", {31'h0, xfer_start}, 32'h0);
    chk(ss_n == 8'h5A, "R12 auto busy ss_n", {24'h0, ss_n}, 32'h5A);
    rd(5'h10, 32'h0000_3108, "R6 go reads set");

    // R8 writes while busy
    wr(5'h10, 32'h0, "R8 ctrl write busy ack");
    wr(5'h00, 32'hDEAD_BEEF, "R8 tx write busy ack");
    chk(tx_data[31:0] == 32'hA0A0_A0A0, "R8 tx word frozen", tx_data[31:0], 32'hA0A0_A0A0);
    rd(5'h10, 32'h0000_3108, "R8 ctrl frozen");

    // R7 / R9 / R10 done with interrupt enabled
    done_pulse();
    chk(irq, "R9 irq on done", {31'h0, irq}, 32'h1);
    rd(5'h10, 32'h0000_3008, "R7 go self-clears");
    chk(!irq, "R10 read clears irq", {31'h0, irq}, 32'h0);
    chk(ss_n == 8'hFF, "R12 auto after done ss_n", {24'h0, ss_n}, 32'hFF);

    // R9 interrupt disabled
    wr(5'h10, 32'h0000_2108, "R9 go without ie");
    done_pulse();
    chk(!irq, "R9 no irq when ie clear", {31'h0, irq}, 32'h0);
    rd(5'h10, 32'h0000_2008, "R7 go clears again");

    // R10 write clears irq
    wr(5'h10, 32'h0000_1108, "R10 go with ie");
    done_pulse();
    chk(irq, "R9 irq set again", {31'h0, irq}, 32'h1);
    wr(5'h14, 32'h0000_0042, "R10 divider write");
    chk(!irq, "R10 write clears irq", {31'h0, irq}, 32'h0);

    // R3 partial byte select
    bus_xfer(1'b1, 5'h14, 32'h0000_1234, 4'b0111);
    chk(g_err && !g_ack, "R3 error response", {30'h0, g_ack, g_err}, 32'h1);
    rd(5'h14, 32'h0000_0042, "R3 divider unchanged");

    tick();
    chk(exp_q.size() == 0, "R2 all reads acknowledged", exp_q.size(), 32'h0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule